// File: doc/BRIEF.md
# Asynchronous Memory Strobe Timing Controller

This block turns single read or write requests into the chip-enable, output-enable and write-enable pulse train of an asynchronous external memory port, such as the data port of a NAND flash device. Each access runs through three phases in order: setup, strobe and hold. Reads and writes each have their own programmable setup, strobe and hold lengths. Every programmed length counts as one cycle more than its value, so a field programmed to zero still lasts one cycle.

A requester raises `req_valid` while `req_ready` is high. The access is accepted on that clock edge. The controller drives the memory pins until the access ends. It then returns a one-cycle `done` pulse, and for a read `rd_data` holds the captured word.

Several options shape each access:
- A wait input from the memory lengthens the strobe phase.
- Idle turnaround cycles are inserted when the transfer direction changes.
- A select-strobe option limits chip-enable to the strobe phase.
- A width option chooses between an 8-bit and a 16-bit data bus.

Top module: `async_strobe_ctrl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` and `done` are low, and `req_ready` is high.
- R2: Each phase lasts its programmed value plus one cycle. A read programmed setup 0, strobe 3, hold 2 holds `mem_oe_n` low for 4 cycles and `mem_ce_n` low for 8 cycles.
- R3: A write programmed setup 0, strobe 7, hold 6 lasts 16 cycles with `mem_ce_n` low, of which 8 have `mem_we_n` low. `mem_dq_oe` is high while `mem_we_n` is low.
- R4: Reads use only the read timing fields and writes use only the write timing fields.
- R5: With `cfg_sel_strobe` low, `mem_ce_n` is low for the whole access. `mem_oe_n` goes low only during the strobe of a read, and `mem_we_n` only during the strobe of a write.
- R6: With `cfg_sel_strobe` high, `mem_ce_n` is low only in the strobe cycles, together with `mem_oe_n` or `mem_we_n`.
- R7: Each cycle in which `mem_wait` is sampled high during the strobe phase adds exactly one strobe cycle.
- R8: `mem_wait` has no effect during the setup and hold phases.
- R9: Read data is captured at the clock edge that ends the last strobe cycle. `done` is high for exactly one cycle, the cycle after the last hold cycle, and `rd_data` is valid while `done` is high.
- R10: With `cfg_wide` low, only bits 7:0 carry data: the upper byte of `mem_dq_out` and of `rd_data` is zero. With `cfg_wide` high, all 16 bits are driven and captured.
- R11: When an access changes direction from the previous one, `cfg_turn` idle cycles with `mem_ce_n` high come before its setup phase. Two accesses in the same direction get no turnaround cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd_setup | input | PHASE_W | Read setup length minus one |
| cfg_rd_strobe | input | PHASE_W | Read strobe length minus one |
| cfg_rd_hold | input | PHASE_W | Read hold length minus one |
| cfg_wr_setup | input | PHASE_W | Write setup length minus one |
| cfg_wr_strobe | input | PHASE_W | Write strobe length minus one |
| cfg_wr_hold | input | PHASE_W | Write hold length minus one |
| cfg_turn | input | TURN_W | Idle cycles inserted on a direction change |
| cfg_sel_strobe | input | 1 | 1: chip-enable only during the strobe phase |
| cfg_wide | input | 1 | 1: 16-bit bus, 0: 8-bit bus on bits 7:0 |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read data |
| mem_ce_n | output | 1 | Chip-enable, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven to memory |
| mem_dq_oe | output | 1 | Data output enable during writes |
| mem_dq_in | input | DATA_W | Data from memory |
| mem_wait | input | 1 | Memory wait, stretches the strobe phase |

## Verification
A phase counter loaded with a wrong value, or a phase that advances early, changes the number of low cycles on `mem_ce_n`, `mem_oe_n` or `mem_we_n` in the same access. It also moves `done` away from its expected cycle. A read that samples in the wrong strobe cycle returns a word that differs in its low byte, because the memory model changes its data on every strobe cycle. A wrong direction record shows as missing or extra turnaround cycles in the very next access.

// File: rtl/async_strobe_ctrl.sv
module async_strobe_ctrl #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int PHASE_W = 5,
  parameter int TURN_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] cfg_rd_setup,
  input  logic [PHASE_W-1:0] cfg_rd_strobe,
  input  logic [PHASE_W-1:0] cfg_rd_hold,
  input  logic [PHASE_W-1:0] cfg_wr_setup,
  input  logic [PHASE_W-1:0] cfg_wr_strobe,
  input  logic [PHASE_W-1:0] cfg_wr_hold,
  input  logic [TURN_W-1:0]  cfg_turn,
  input  logic               cfg_sel_strobe,
  input  logic               cfg_wide,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ready,
  output logic               done,
  output logic [DATA_W-1:0]  rd_data,
  output logic               mem_ce_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_dq_out,
  output logic               mem_dq_oe,
  input  logic [DATA_W-1:0]  mem_dq_in,
  input  logic               mem_wait
);
  localparam int LANE_W = DATA_W / 2;
  localparam int CNT_W  = (PHASE_W > TURN_W) ? PHASE_W : TURN_W;

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_SETUP, S_STROBE, S_HOLD} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic               op_wr, last_wr, have_last;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;

  logic [CNT_W-1:0] setup_v, strobe_v, hold_v, new_setup_v;
  logic [DATA_W-1:0] lane_in, lane_wr;
  logic active, strobe, dir_change;

  assign setup_v     = CNT_W'(op_wr ? cfg_wr_setup  : cfg_rd_setup);
  assign strobe_v    = CNT_W'(op_wr ? cfg_wr_strobe : cfg_rd_strobe);
  assign hold_v      = CNT_W'(op_wr ? cfg_wr_hold   : cfg_rd_hold);
  assign new_setup_v = CNT_W'(req_write ? cfg_wr_setup : cfg_rd_setup);
  assign dir_change  = have_last && (last_wr != req_write) && (cfg_turn != '0);

  assign lane_in = cfg_wide ? mem_dq_in : {{LANE_W{1'b0}}, mem_dq_in[LANE_W-1:0]};
  assign lane_wr = cfg_wide ? req_wdata : {{LANE_W{1'b0}}, req_wdata[LANE_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      op_wr     <= 1'b0;
      last_wr   <= 1'b0;
      have_last <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rd_data   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          op_wr     <= req_write;
          last_wr   <= req_write;
          have_last <= 1'b1;
          addr_q    <= req_addr;
          wdata_q   <= lane_wr;
          if (dir_change) begin
            state <= S_TURN;
            cnt   <= CNT_W'(cfg_turn) - 1'b1;
          end else begin
            state <= S_SETUP;
            cnt   <= new_setup_v;
          end
        end
        S_TURN:
          if (cnt == '0) begin
            state <= S_SETUP;
            cnt   <= setup_v;
          end else cnt <= cnt - 1'b1;
        S_SETUP:
          if (cnt == '0) begin
            state <= S_STROBE;
            cnt   <= strobe_v;
          end else cnt <= cnt - 1'b1;
        S_STROBE:
          if (!mem_wait) begin
            if (cnt == '0) begin
              state <= S_HOLD;
              cnt   <= hold_v;
              if (!op_wr) rd_data <= lane_in;
            end else cnt <= cnt - 1'b1;
          end
        S_HOLD:
          if (cnt == '0) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign active     = (state == S_SETUP) || (state == S_STROBE) || (state == S_HOLD);
  assign strobe     = (state == S_STROBE);
  assign req_ready  = (state == S_IDLE);
  assign mem_ce_n   = !(cfg_sel_strobe ? strobe : active);
  assign mem_oe_n   = !(strobe && !op_wr);
  assign mem_we_n   = !(strobe && op_wr);
  assign mem_dq_oe  = active && op_wr;
  assign mem_dq_out = wdata_q;
  assign mem_addr   = addr_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  // R5
  strobe_under_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_ce_n);

  // R3
  write_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  // R7
  wait_holds_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && mem_wait) |=> strobe);

  // R8
  setup_ignores_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SETUP && cnt == '0) |=> strobe);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  turn_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TURN) |-> (mem_ce_n && mem_oe_n && mem_we_n));
endmodule

// File: tb/async_strobe_ctrl_test.sv
module async_strobe_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  rd_s, rd_t, rd_h, wr_s, wr_t, wr_h;
  logic [2:0]  turn;
  logic        sel, wide;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_ready, done;
  logic [15:0] rd_data;
  logic        ce_n, oe_n, we_n, dq_oe;
  logic [11:0] mem_addr;
  logic [15:0] dq_out, dq_in;
  logic        mem_wait;

  async_strobe_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_setup(rd_s), .cfg_rd_strobe(rd_t), .cfg_rd_hold(rd_h),
    .cfg_wr_setup(wr_s), .cfg_wr_strobe(wr_t), .cfg_wr_hold(wr_h),
    .cfg_turn(turn), .cfg_sel_strobe(sel), .cfg_wide(wide),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rd_data(rd_data),
    .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n), .mem_addr(mem_addr),
    .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_dq_in(dq_in), .mem_wait(mem_wait)
  );

  int checks = 0;
  int errors = 0;
  int n_cyc, n_ce, n_oe, n_we, n_done;
  logic [15:0] got_rd, got_wr;
  logic        wr_oe_ok;
  logic [11:0] got_addr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // wmode 0: no wait, 1: wait for 'budget' strobe cycles, 2: wait outside strobe
  task automatic access(input bit wr, input logic [11:0] a, input logic [15:0] wd,
                        input logic [15:0] base, input int wmode, input int budget);
    int left = budget;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; dq_in = base;
    @(negedge clk);
    req_valid = 1'b0;
    n_cyc = 0; n_ce = 0; n_oe = 0; n_we = 0; n_done = 0; wr_oe_ok = 1'b1;
    got_addr = mem_addr;
    for (int i = 0; i < 200; i++) begin
      n_cyc++;
      if (!ce_n) n_ce++;
      if (!oe_n) begin n_oe++; dq_in = base + 16'(n_oe); end
      if (!we_n) begin n_we++; got_wr = dq_out; if (!dq_oe) wr_oe_ok = 1'b0; end
      if (wmode == 1) begin
        if ((!oe_n || !we_n) && left > 0) begin mem_wait = 1'b1; left--; end
        else mem_wait = 1'b0;
      end else if (wmode == 2) mem_wait = !ce_n && oe_n && we_n;
      else mem_wait = 1'b0;
      if (done) begin n_done++; got_rd = rd_data; break; end
      @(negedge clk);
    end
    mem_wait = 1'b0;
    @(negedge clk);
    if (done) n_done++;
  endtask

  task automatic t_reset();
    chk(ce_n && oe_n && we_n, "R1 strobes idle high", {ce_n, oe_n, we_n}, 3'b111);
    chk(!dq_oe && !done, "R1 dq_oe/done low", {dq_oe, done}, 0);
    chk(req_ready, "R1 ready", req_ready, 1);
  endtask

  task automatic t_read_basic();
    rd_s = 0; rd_t = 3; rd_h = 2;
    access(1'b0, 12'h123, 16'h0, 16'h5510, 0, 0);
    chk(n_oe == 4, "R2 oe low cycles", n_oe, 4);
    chk(n_ce == 8, "R2/R5 ce low whole read", n_ce, 8);
    chk(n_we == 0, "R5 no we on read", n_we, 0);
    chk(n_cyc == 9, "R9 done one cycle after hold", n_cyc, 9);
    chk(n_done == 1, "R9 single done pulse", n_done, 1);
    chk(got_rd == 16'h0014, "R9/R10 last strobe sample, 8-bit", got_rd, 16'h0014);
    chk(got_addr == 12'h123, "R2 address", got_addr, 12'h123);
  endtask

  task automatic t_write_basic();
    wr_s = 0; wr_t = 7; wr_h = 6;
    access(1'b1, 12'h045, 16'hBEEF, 16'h0, 0, 0);
    chk(n_ce == 16, "R3 write ce low", n_ce, 16);
    chk(n_we == 8, "R3 we low", n_we, 8);
    chk(n_oe == 0, "R5 no oe on write", n_oe, 0);
    chk(wr_oe_ok, "R3 dq_oe during we", wr_oe_ok, 1);
    chk(got_wr == 16'h00EF, "R10 8-bit write data", got_wr, 16'h00EF);
    chk(n_cyc == 17, "R3 write done timing", n_cyc, 17);
  endtask

  task automatic t_independent();
    rd_s = 2; rd_t = 1; rd_h = 0;
    access(1'b0, 12'h001, 16'h0, 16'h0020, 0, 0);
    chk(n_ce == 6, "R4 read fields only", n_ce, 6);
    chk(n_oe == 2, "R4 read strobe", n_oe, 2);
    access(1'b1, 12'h002, 16'h0033, 16'h0, 0, 0);
    chk(n_ce == 16, "R4 write unchanged by read fields", n_ce, 16);
  endtask

  task automatic t_select();
    sel = 1'b1; rd_s = 1; rd_t = 4; rd_h = 1;
    access(1'b0, 12'h010, 16'h0, 16'h0040, 0, 0);
    chk(n_ce == 5, "R6 ce only in strobe", n_ce, 5);
    chk(n_oe == 5, "R6 oe strobe", n_oe, 5);
    chk(n_cyc == 10, "R6 access length", n_cyc, 10);
    sel = 1'b0;
  endtask

  task automatic t_wait();
    rd_s = 0; rd_t = 3; rd_h = 2;
    access(1'b0, 12'h011, 16'h0, 16'h0050, 1, 3);
    chk(n_oe == 7, "R7 wait stretches strobe", n_oe, 7);
    chk(n_ce == 11, "R7 ce stretched", n_ce, 11);
    chk(got_rd == 16'h0057, "R7/R9 sample after wait", got_rd, 16'h0057);
  endtask

  task automatic t_wait_ignored();
    rd_s = 2; rd_t = 3; rd_h = 2;
    access(1'b0, 12'h012, 16'h0, 16'h0060, 2, 0);
    chk(n_ce == 10, "R8 wait ignored in setup/hold", n_ce, 10);
    chk(n_oe == 4, "R8 strobe unchanged", n_oe, 4);
    chk(n_cyc == 11, "R8 done timing", n_cyc, 11);
  endtask

  task automatic t_wide();
    wide = 1'b1; rd_s = 0; rd_t = 3; rd_h = 2;
    access(1'b0, 12'h020, 16'h0, 16'hC310, 0, 0);
    chk(got_rd == 16'hC314, "R10 16-bit read", got_rd, 16'hC314);
    access(1'b1, 12'h021, 16'h1234, 16'h0, 0, 0);
    chk(got_wr == 16'h1234, "R10 16-bit write", got_wr, 16'h1234);
    wide = 1'b0;
  endtask

  task automatic t_turn();
    turn = 3'd3;
    access(1'b1, 12'h030, 16'h0011, 16'h0, 0, 0);
    chk(n_cyc == 17, "R11 no turnaround write-write", n_cyc, 17);
    access(1'b0, 12'h031, 16'h0, 16'h0070, 0, 0);
    chk(n_cyc == 12, "R11 turnaround write-read", n_cyc, 12);
    chk(n_ce == 8, "R11 ce high in turnaround", n_ce, 8);
    access(1'b0, 12'h032, 16'h0, 16'h0070, 0, 0);
    chk(n_cyc == 9, "R11 no turnaround read-read", n_cyc, 9);
    access(1'b1, 12'h033, 16'h0022, 16'h0, 0, 0);
    chk(n_cyc == 20, "R11 turnaround read-write", n_cyc, 20);
  endtask

  initial begin
    rd_s = 0; rd_t = 0; rd_h = 0; wr_s = 0; wr_t = 0; wr_h = 0;
    turn = 0; sel = 0; wide = 0;
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    dq_in = 0; mem_wait = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_basic();
    t_write_basic();
    t_independent();
    t_select();
    t_wait();
    t_wait_ignored();
    t_wide();
    t_turn();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule